// File: doc/BRIEF.md
# SPI Controller with Mode-Fault Detection

This block is a byte-oriented serial peripheral interface engine that can act either as the clocking side (master) or as the clocked side (slave) of a four-wire link. Software sets it up through a small byte-wide register port. One configuration register selects master or slave operation, clock idle level, clock phase and bit order. A second holds the mode-fault enable, the select-output enable and two spare storage bits. Writing the data register starts a frame in master mode, or preloads the outgoing byte in slave mode. Reading the data register returns the last byte received.

The slave-select pin's role is decided by the master/slave bit, the mode-fault enable and the select-output enable taken together. In master mode the pin can be left to general-purpose use, watched as a mode-fault input, or driven low automatically for the length of each frame. In slave mode it is always the select input. A master that sees its select input pulled low while fault detection is armed raises a sticky fault flag. It then falls back to slave mode and releases its clock and data outputs. Pins are split into separate input, output and output-enable signals so the pad logic stays outside the block. In slave mode the pin inputs are synchronised to the system clock, so the serial clock must be several times slower than the system clock.

Top module: `spi_ctl`

## Requirements
- R1: After reset every register reads 0x00, and sck_oe, mosi_oe, miso_oe, ss_oe and mode_fault are all 0.
- R2: The select register (address 1) stores bits 4, 3, 1 and 0. Bits 7, 6, 5 and 2 always read 0. Bit 4 arms mode-fault detection and bit 3 enables the automatic select output.
- R3: In master mode (address 0 bit 7 = 1), writing address 2 starts a frame of 16 serial-clock edges spaced DIV_HALF system cycles apart. Between frames sck_o rests at the polarity bit (address 0 bit 6).
- R4: With phase bit (address 0 bit 5) at 0, the first data bit is on the data output before the first clock edge, data is sampled on leading edges and changed on trailing edges. With phase 1, data is changed on leading edges and sampled on trailing edges.
- R5: Address 0 bit 4 = 0 sends and receives the most significant bit first; 1 sends and receives the least significant bit first.
- R6: At the end of a frame the received byte becomes readable at address 2 and status bit 7 (address 3) is set. It stays set until software writes 1 to that bit.
- R7: In master mode with fault detection disarmed, ss_oe stays 0 and a low select input neither flags a fault nor stops a frame, whatever the output-enable bit holds.
- R8: In master mode with fault detection armed and the output enable set, ss_oe is 1 and ss_o is low exactly while a frame runs.
- R9: In master mode with fault detection armed and the output enable clear, a low select input sets status bit 6 and mode_fault, clears address 0 bit 7, and drops sck_oe and mosi_oe. Writing 1 to status bit 6 clears the flag.
- R10: In slave mode ss_oe and sck_oe are 0 for every select-register setting. miso_oe is 1 only while ss_i is low, and with phase 0 the first outgoing bit is on miso_o before the first clock edge.
- R11: In slave mode a rising ss_i abandons a partial frame, and the next full frame is received correctly.
- R12: A data write while a master frame is running is ignored and does not disturb the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 mode, 1 select, 2 data, 3 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| sck_i | input | 1 | Serial clock from pad (slave mode) |
| sck_o | output | 1 | Serial clock to pad (master mode) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-out line from pad (slave mode) |
| mosi_o | output | 1 | Master-out line to pad |
| mosi_oe | output | 1 | Master-out output enable |
| miso_i | input | 1 | Master-in line from pad (master mode) |
| miso_o | output | 1 | Master-in line to pad (slave mode) |
| miso_oe | output | 1 | Master-in output enable |
| ss_i | input | 1 | Slave-select from pad |
| ss_o | output | 1 | Automatic slave-select output |
| ss_oe | output | 1 | Slave-select output enable |
| mode_fault | output | 1 | Sticky mode-fault flag |

## Verification
The hardest situation to reach is a slave frame cut short by slave select rising in mid-frame, followed by a clean frame. The bench acts as an external master on the pad inputs: it drives three bit periods, raises select, reloads the outgoing byte and then runs a full frame whose received byte must be exact. Mode fault needs a master armed for fault detection while the select input falls. The bench gets there by writing the two configuration registers and then pulling ss_i low. The eight clock formats are covered by a behavioural slave in the bench that follows sck_o and decides its own sample and change edges from the requirement text.

// File: rtl/spi_ctl_pkg.sv
// Shared types and constants for the SPI controller.
// Assumes a byte-wide register port with four addresses.
package spi_ctl_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_MODE = 2'd0;
    localparam logic [ADDR_W-1:0] A_SSEL = 2'd1;
    localparam logic [ADDR_W-1:0] A_DATA = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

    typedef struct packed {
        logic master;
        logic cpol;
        logic cpha;
        logic lsb_first;
    } spi_mode_t;

    typedef enum logic [1:0] {
        SS_FREE     = 2'd0,
        SS_FAULT_IN = 2'd1,
        SS_AUTO_OUT = 2'd2,
        SS_SLAVE_IN = 2'd3
    } ss_role_t;

    // Decide what the slave-select pin does from the three control bits.
    function automatic ss_role_t ss_role_f(input logic master, input logic mf_en,
                                           input logic auto_oe);
        if (!master)      return SS_SLAVE_IN;
        else if (!mf_en)  return SS_FREE;
        else if (auto_oe) return SS_AUTO_OUT;
        else              return SS_FAULT_IN;
    endfunction

endpackage

// File: rtl/spi_ctl_sync.sv
// Two-stage synchroniser for asynchronous pad inputs.
// Assumes the inputs change slowly relative to clk.
module spi_ctl_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two flops in series to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/spi_ctl_regs.sv
// Register file: mode, select, data and status registers.
// Assumes single-cycle bus writes; reads are combinational on bus_addr.
module spi_ctl_regs
    import spi_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output spi_mode_t         mode,
    output logic              mf_en,
    output logic              ss_auto,
    output logic              data_wr,
    output logic              flag_done,
    output logic              flag_fault,
    input  logic              fault_set,
    input  logic              done_set,
    input  logic [REG_W-1:0]  rx_in
);
    spi_mode_t        mode_q;
    logic             mf_en_q;
    logic             ss_auto_q;
    logic [1:0]       spare_q;
    logic             done_q;
    logic             fault_q;
    logic [REG_W-1:0] rxbuf_q;
    logic             wr_stb;

    assign wr_stb  = bus_sel && bus_wr;
    assign data_wr = wr_stb && (bus_addr == A_DATA);

    // Configuration storage; a mode fault forces slave mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= '0;
            mf_en_q   <= 1'b0;
            ss_auto_q <= 1'b0;
            spare_q   <= '0;
        end else begin
            if (wr_stb && bus_addr == A_MODE)
                mode_q <= spi_mode_t'(bus_wdata[7:4]);
            if (wr_stb && bus_addr == A_SSEL) begin
                mf_en_q   <= bus_wdata[4];
                ss_auto_q <= bus_wdata[3];
                spare_q   <= bus_wdata[1:0];
            end
            if (fault_set)
                mode_q.master <= 1'b0;
        end
    end

    // Sticky flags and receive buffer; set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            rxbuf_q <= '0;
        end else begin
            if (wr_stb && bus_addr == A_STAT) begin
                if (bus_wdata[7]) done_q  <= 1'b0;
                if (bus_wdata[6]) fault_q <= 1'b0;
            end
            if (done_set) begin
                done_q  <= 1'b1;
                rxbuf_q <= rx_in;
            end
            if (fault_set)
                fault_q <= 1'b1;
        end
    end

    // Read multiplexer with unimplemented bits tied low.
    always_comb begin
        case (bus_addr)
            A_MODE:  bus_rdata = {mode_q, 4'b0000};
            A_SSEL:  bus_rdata = {3'b000, mf_en_q, ss_auto_q, 1'b0, spare_q};
            A_DATA:  bus_rdata = rxbuf_q;
            default: bus_rdata = {done_q, fault_q, 6'b000000};
        endcase
    end

    assign mode       = mode_q;
    assign mf_en      = mf_en_q;
    assign ss_auto    = ss_auto_q;
    assign flag_done  = done_q;
    assign flag_fault = fault_q;
endmodule

// File: rtl/spi_ctl_shift.sv
// Frame shifter shared by master and slave: counts clock edges, shifts the
// outgoing byte on change edges and gathers incoming bits on sample edges.
// Assumes one edge_stb pulse per serial-clock edge, 2*DATA_W per frame.
module spi_ctl_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              edge_stb,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              din,
    output logic              dout,
    output logic [DATA_W-1:0] rx_next,
    output logic              last_sample,
    output logic              last_edge
);
    localparam int EDGES = 2 * DATA_W;
    localparam int EW    = $clog2(EDGES);

    logic [EW-1:0]     edge_q;
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic              sample_edge;
    logic              change_edge;
    logic              do_sample;

    // Phase 0 samples on even (leading) edges, phase 1 on odd (trailing) edges.
    assign sample_edge = (edge_q[0] == cpha);
    assign change_edge = !sample_edge && !(cpha && edge_q == '0);
    assign do_sample   = edge_stb && sample_edge;
    assign last_sample = do_sample && (edge_q[EW-1:1] == (EW-1)'(DATA_W-1));
    assign last_edge   = edge_stb && (edge_q == EW'(EDGES-1));
    assign dout        = lsb_first ? tx_q[0] : tx_q[DATA_W-1];

    // Next receive value, including the bit sampled this cycle.
    always_comb begin
        if (!do_sample)     rx_next = rx_q;
        else if (lsb_first) rx_next = {din, rx_q[DATA_W-1:1]};
        else                rx_next = {rx_q[DATA_W-2:0], din};
    end

    // Edge counter and shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
        end else if (load) begin
            edge_q <= '0;
            tx_q   <= load_data;
        end else if (clear) begin
            edge_q <= '0;
        end else if (edge_stb) begin
            edge_q <= edge_q + 1'b1;
            rx_q   <= rx_next;
            if (change_edge)
                tx_q <= lsb_first ? (tx_q >> 1) : (tx_q << 1);
        end
    end
endmodule

// File: rtl/spi_ctl_mtimer.sv
// Master clock generator: while a frame runs, emits an edge strobe every
// DIV_HALF cycles and toggles the serial clock, which idles at cpol.
// Assumes DIV_HALF >= 2.
module spi_ctl_mtimer #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    input  logic cpol,
    input  logic last_edge,
    output logic busy,
    output logic edge_stb,
    output logic sck
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic          act_q;

    assign edge_stb = busy_q && (cnt_q == CW'(DIV_HALF - 1));
    assign busy     = busy_q;
    assign sck      = act_q ^ cpol;

    // Half-period counter, frame activity and unpolarised clock level.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            act_q  <= 1'b0;
        end else if (start && !busy_q) begin
            cnt_q  <= '0;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (edge_stb) begin
                cnt_q <= '0;
                act_q <= !act_q;
                if (last_edge)
                    busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_ctl.sv
// SPI controller top: register file, master clock timer, shared frame
// shifter and slave-select role logic with mode-fault detection.
// Assumes clk is at least six times the serial clock rate in slave mode.
module spi_ctl
    import spi_ctl_pkg::*;
#(
    parameter int DIV_HALF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              ss_i,
    output logic              ss_o,
    output logic              ss_oe,
    output logic              mode_fault
);
    spi_mode_t        cfg_mode;
    logic             cfg_mf_en;
    logic             cfg_ss_auto;
    logic             data_wr;
    logic             flag_done;
    logic             flag_fault;
    logic             fault_set;
    logic             done_set;
    logic [REG_W-1:0] rx_next;
    logic             sh_dout;
    logic             sh_last_sample;
    logic             sh_last_edge;
    logic             m_busy;
    logic             m_edge;
    logic             m_sck;
    logic             m_start;
    logic [2:0]       pad_s;
    logic             sck_s;
    logic             mosi_s;
    logic             ss_s;
    logic             sck_d_q;
    logic             s_edge;
    ss_role_t         ss_role;
    logic             is_master;

    spi_ctl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .mode       (cfg_mode),
        .mf_en      (cfg_mf_en),
        .ss_auto    (cfg_ss_auto),
        .data_wr    (data_wr),
        .flag_done  (flag_done),
        .flag_fault (flag_fault),
        .fault_set  (fault_set),
        .done_set   (done_set),
        .rx_in      (rx_next)
    );

    spi_ctl_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ss_i, mosi_i, sck_i}),
        .q     (pad_s)
    );

    assign sck_s  = pad_s[0];
    assign mosi_s = pad_s[1];
    assign ss_s   = pad_s[2];

    assign is_master = cfg_mode.master;
    assign ss_role   = ss_role_f(is_master, cfg_mf_en, cfg_ss_auto);
    assign fault_set = (ss_role == SS_FAULT_IN) && !ss_s;
    assign m_start   = data_wr && is_master && !m_busy && !fault_set;

    // Delayed synchronised clock for slave edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d_q <= 1'b0;
        else        sck_d_q <= sck_s;
    end

    assign s_edge = !is_master && !ss_s && (sck_s != sck_d_q);

    spi_ctl_mtimer #(.DIV_HALF(DIV_HALF)) u_mtimer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (m_start),
        .abort     (fault_set),
        .cpol      (cfg_mode.cpol),
        .last_edge (sh_last_edge),
        .busy      (m_busy),
        .edge_stb  (m_edge),
        .sck       (m_sck)
    );

    spi_ctl_shift #(.DATA_W(REG_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (!is_master && ss_s),
        .load        (is_master ? m_start : data_wr),
        .load_data   (bus_wdata),
        .edge_stb    (is_master ? m_edge : s_edge),
        .cpha        (cfg_mode.cpha),
        .lsb_first   (cfg_mode.lsb_first),
        .din         (is_master ? miso_i : mosi_s),
        .dout        (sh_dout),
        .rx_next     (rx_next),
        .last_sample (sh_last_sample),
        .last_edge   (sh_last_edge)
    );

    assign done_set = is_master ? (m_edge && sh_last_edge) : sh_last_sample;

    assign sck_o      = m_sck;
    assign sck_oe     = is_master;
    assign mosi_o     = sh_dout;
    assign mosi_oe    = is_master;
    assign miso_o     = sh_dout;
    assign miso_oe    = !is_master && !ss_s;
    assign ss_o       = !m_busy;
    assign ss_oe      = (ss_role == SS_AUTO_OUT);
    assign mode_fault = flag_fault;
endmodule

// File: rtl/spi_ctl_chk.sv
// Property checker for spi_ctl, attached with bind.
// Observes register outputs, timer state and pins.
module spi_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       master,
    input logic       cpol,
    input logic       mf_en,
    input logic       ss_auto,
    input logic       busy,
    input logic       fault_set,
    input logic       flag_fault,
    input logic       flag_done,
    input logic       sck_o,
    input logic       sck_oe,
    input logic       mosi_oe,
    input logic       ss_o,
    input logic       ss_oe,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata
);
    // R2
    ssel_unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd1) |-> (bus_rdata[7:5] == 3'b000 && !bus_rdata[2]));

    // R3
    idle_clock_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master && !busy) |-> (sck_o == cpol));

    // R8
    auto_select_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master && mf_en && ss_auto && busy) |-> (ss_oe && !ss_o));

    // R9
    fault_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_set |=> (flag_fault && !sck_oe && !mosi_oe && !busy));

    // R10
    slave_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master |-> (!sck_oe && !ss_oe));

    // R6
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_done && !(bus_sel && bus_wr && bus_addr == 2'd3 && bus_wdata[7]))
        |=> flag_done);
endmodule

bind spi_ctl spi_ctl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .master     (cfg_mode.master),
    .cpol       (cfg_mode.cpol),
    .mf_en      (cfg_mf_en),
    .ss_auto    (cfg_ss_auto),
    .busy       (m_busy),
    .fault_set  (fault_set),
    .flag_fault (flag_fault),
    .flag_done  (flag_done),
    .sck_o      (sck_o),
    .sck_oe     (sck_oe),
    .mosi_oe    (mosi_oe),
    .ss_o       (ss_o),
    .ss_oe      (ss_oe),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata)
);

// File: tb/tb_spi_ctl.sv
// Self-checking bench for spi_ctl: vector table of master frames, then
// directed tests for reset, select-pin roles, slave mode and corner cases.
module tb_spi_ctl;
    localparam int HALF  = 4;   // DIV_HALF default of the design
    localparam int SHALF = 8;   // bench half period when driving a slave

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_i = 1'b1;
    logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_o, ss_oe, mode_fault;

    int checks = 0;
    int fails  = 0;

    spi_ctl dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .ss_i(ss_i), .ss_o(ss_o), .ss_oe(ss_oe), .mode_fault(mode_fault)
    );

    always #2 clk = !clk;  // 250 MHz

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic bitof(input logic [7:0] p, input logic lsb, input int i);
        return lsb ? p[i] : p[7-i];
    endfunction

    // Behavioural slave following sck_o for master-mode tests.
    logic       mdl_on = 1'b0, mdl_cpol = 1'b0, mdl_cpha = 1'b0, mdl_lsb = 1'b0;
    logic [7:0] mdl_pat = 8'h00, mdl_cap = 8'h00;
    int         mdl_idx = 0, mdl_tog = 0;
    time        t_e0 = 0, t_e1 = 0;

    always @(sck_o) begin
        if (mdl_on) begin
            if (mdl_tog == 0) t_e0 = $time;
            if (mdl_tog == 1) t_e1 = $time;
            mdl_tog++;
            if ((sck_o ^ mdl_cpol) != mdl_cpha) begin
                mdl_cap = mdl_lsb ? {mosi_o, mdl_cap[7:1]} : {mdl_cap[6:0], mosi_o};
            end else begin
                if (mdl_idx < 8) miso_i = bitof(mdl_pat, mdl_lsb, mdl_idx);
                mdl_idx++;
            end
        end
    end

    task automatic mdl_arm(input logic [7:0] cfga, input logic [7:0] pat);
        mdl_cpol = cfga[6]; mdl_cpha = cfga[5]; mdl_lsb = cfga[4];
        mdl_pat = pat; mdl_cap = 8'h00; mdl_tog = 0;
        if (!cfga[5]) begin
            miso_i = bitof(pat, cfga[4], 0);
            mdl_idx = 1;
        end else begin
            mdl_idx = 0;
        end
        mdl_on = 1'b1;
    endtask

    // Bench acting as an external master toward the DUT in slave mode.
    task automatic drive_slave(input logic cpol, input logic cpha, input logic lsb,
                               input logic [7:0] pat, input int nbits,
                               output logic [7:0] got, output logic oe_seen,
                               output logic first_bit);
        got = 8'h00;
        sck_i = cpol;
        repeat (SHALF) @(negedge clk);
        ss_i = 1'b0;
        if (!cpha) mosi_i = bitof(pat, lsb, 0);
        repeat (SHALF) @(negedge clk);
        oe_seen = miso_oe;
        first_bit = miso_o;
        for (int i = 0; i < nbits; i++) begin
            sck_i = !cpol;
            if (cpha) mosi_i = bitof(pat, lsb, i);
            else      got = lsb ? {miso_o, got[7:1]} : {got[6:0], miso_o};
            repeat (SHALF) @(negedge clk);
            sck_i = cpol;
            if (cpha)          got = lsb ? {miso_o, got[7:1]} : {got[6:0], miso_o};
            else if (i + 1 < 8) mosi_i = bitof(pat, lsb, i + 1);
            repeat (SHALF) @(negedge clk);
        end
        ss_i = 1'b1;
        repeat (SHALF) @(negedge clk);
    endtask

    // Vectors: {mode register, byte sent by DUT, byte sent by bench slave}
    localparam logic [23:0] VEC [8] = '{
        {8'h80, 8'hA5, 8'h3C}, {8'h90, 8'h01, 8'h80},
        {8'hA0, 8'hC3, 8'h5A}, {8'hB0, 8'h7E, 8'h81},
        {8'hC0, 8'h0F, 8'hF0}, {8'hD0, 8'h96, 8'h69},
        {8'hE0, 8'hFF, 8'h00}, {8'hF0, 8'h12, 8'hED}
    };

    initial begin
        #700000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic [7:0] got;
        logic       oe_seen, fb;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), r);
            check(r == 8'h00, "R1 register reset", r, 0);
        end
        check({sck_oe, mosi_oe, miso_oe, ss_oe, mode_fault} == 5'b0, "R1 enables reset",
              {sck_oe, mosi_oe, miso_oe, ss_oe, mode_fault}, 0);

        // R3 R4 R5 R6: master frames in all eight formats
        for (int v = 0; v < 8; v++) begin
            logic [7:0] cfga, tx, pat;
            {cfga, tx, pat} = VEC[v];
            wr(2'd0, cfga);
            @(negedge clk);
            check(sck_o == cfga[6], "R3 idle level before frame", sck_o, cfga[6]);
            mdl_arm(cfga, pat);
            wr(2'd2, tx);
            repeat (16 * HALF + 8) @(negedge clk);
            mdl_on = 1'b0;
            check(mdl_tog == 16, "R3 edge count", mdl_tog, 16);
            check((t_e1 - t_e0) == HALF * 4, "R3 half period", int'(t_e1 - t_e0), HALF * 4);
            check(sck_o == cfga[6], "R3 idle level after frame", sck_o, cfga[6]);
            check(mdl_cap == tx, "R4 R5 bits sent", mdl_cap, tx);
            rd(2'd3, r);
            check(r[7], "R6 done flag set", r, 8'h80);
            rd(2'd2, r);
            check(r == pat, "R4 R5 R6 bits received", r, pat);
            wr(2'd3, 8'h80);
            rd(2'd3, r);
            check(r == 8'h00, "R6 done flag cleared", r, 0);
        end

        // R6: flag stays set without a clear
        mdl_arm(8'h80, 8'h11);
        wr(2'd0, 8'h80);
        wr(2'd2, 8'h22);
        repeat (16 * HALF + 8) @(negedge clk);
        mdl_on = 1'b0;
        wr(2'd3, 8'h40);
        repeat (20) @(negedge clk);
        rd(2'd3, r);
        check(r[7], "R6 done flag sticky", r, 8'h80);
        wr(2'd3, 8'h80);

        // R12: data write during a frame is ignored
        mdl_arm(8'h80, 8'h00);
        wr(2'd2, 8'hC5);
        repeat (10) @(negedge clk);
        wr(2'd2, 8'h3A);
        repeat (16 * HALF) @(negedge clk);
        mdl_on = 1'b0;
        check(mdl_cap == 8'hC5, "R12 write while busy ignored", mdl_cap, 8'hC5);
        check(mdl_tog == 16, "R12 single frame", mdl_tog, 16);
        wr(2'd3, 8'h80);

        // R2: select register unimplemented bits
        wr(2'd1, 8'hFF);
        rd(2'd1, r);
        check(r == 8'h1B, "R2 select readback", r, 8'h1B);

        // R7: fault detection disarmed, output enable set, select pulled low
        wr(2'd1, 8'h08);
        ss_i = 1'b0;
        mdl_arm(8'h80, 8'h5C);
        wr(2'd2, 8'h93);
        repeat (5) @(negedge clk);
        check(ss_oe == 1'b0, "R7 select not driven", ss_oe, 0);
        repeat (16 * HALF + 4) @(negedge clk);
        mdl_on = 1'b0;
        check(mdl_cap == 8'h93 && mode_fault == 1'b0, "R7 frame completes, no fault",
              {mode_fault, mdl_cap}, 8'h93);
        rd(2'd0, r);
        check(r[7], "R7 still master", r, 8'h80);
        ss_i = 1'b1;
        wr(2'd3, 8'h80);

        // R8: automatic select output
        wr(2'd1, 8'h18);
        @(negedge clk);
        check(ss_oe && ss_o, "R8 select high between frames", {ss_oe, ss_o}, 3);
        mdl_arm(8'h80, 8'h00);
        wr(2'd2, 8'h44);
        repeat (3) @(negedge clk);
        check(ss_oe && !ss_o, "R8 select low during frame", {ss_oe, ss_o}, 2);
        repeat (16 * HALF + 4) @(negedge clk);
        mdl_on = 1'b0;
        check(ss_oe && ss_o, "R8 select high after frame", {ss_oe, ss_o}, 3);
        wr(2'd3, 8'h80);

        // R9: mode fault
        wr(2'd1, 8'h10);
        @(negedge clk);
        check(mode_fault == 1'b0 && ss_oe == 1'b0, "R9 no fault while select high",
              {mode_fault, ss_oe}, 0);
        ss_i = 1'b0;
        repeat (6) @(negedge clk);
        check(mode_fault == 1'b1, "R9 fault pin", mode_fault, 1);
        rd(2'd3, r);
        check(r[6], "R9 fault status bit", r, 8'h40);
        rd(2'd0, r);
        check(r[7] == 1'b0, "R9 dropped to slave", r, 0);
        check(!sck_oe && !mosi_oe, "R9 outputs released", {sck_oe, mosi_oe}, 0);
        ss_i = 1'b1;
        repeat (4) @(negedge clk);
        wr(2'd3, 8'h40);
        rd(2'd3, r);
        check(r == 8'h00 && !mode_fault, "R9 fault cleared", r, 0);

        // R10: slave mode, phase 0, msb first, select register fully set
        wr(2'd1, 8'h18);
        wr(2'd0, 8'h00);
        @(negedge clk);
        check(!ss_oe && !sck_oe && !miso_oe, "R10 slave drives nothing idle",
              {ss_oe, sck_oe, miso_oe}, 0);
        wr(2'd2, 8'hA5);
        drive_slave(1'b0, 1'b0, 1'b0, 8'h3C, 8, got, oe_seen, fb);
        check(oe_seen, "R10 miso driven while selected", oe_seen, 1);
        check(fb == 1'b1, "R10 first bit before first edge", fb, 1);
        check(got == 8'hA5, "R10 slave sent byte", got, 8'hA5);
        check(!miso_oe, "R10 miso released", miso_oe, 0);
        rd(2'd2, r);
        check(r == 8'h3C, "R10 slave received byte", r, 8'h3C);
        rd(2'd3, r);
        check(r[7], "R6 slave done flag", r, 8'h80);
        wr(2'd3, 8'h80);

        // R10 R4 R5: slave, polarity 1, phase 1, lsb first
        wr(2'd0, 8'h70);
        wr(2'd2, 8'h81);
        drive_slave(1'b1, 1'b1, 1'b1, 8'h6E, 8, got, oe_seen, fb);
        check(got == 8'h81, "R10 R5 slave sent byte lsb first", got, 8'h81);
        rd(2'd2, r);
        check(r == 8'h6E, "R10 R4 slave received byte phase 1", r, 8'h6E);
        wr(2'd3, 8'h80);

        // R11: partial frame abandoned on select rising
        wr(2'd0, 8'h00);
        wr(2'd2, 8'hF0);
        drive_slave(1'b0, 1'b0, 1'b0, 8'hFF, 3, got, oe_seen, fb);
        rd(2'd3, r);
        check(r[7] == 1'b0, "R11 no completion on partial frame", r, 0);
        wr(2'd2, 8'h2D);
        drive_slave(1'b0, 1'b0, 1'b0, 8'h4B, 8, got, oe_seen, fb);
        rd(2'd2, r);
        check(r == 8'h4B, "R11 next frame received", r, 8'h4B);
        check(got == 8'h2D, "R11 next frame sent", got, 8'h2D);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule